// File: doc/BRIEF.md
# Video Line Fetch Burst Controller

This block keeps a video FIFO topped up from a frame buffer in memory. It watches the FIFO fill level against a programmable watermark. When there is room, it raises a burst read request on a simple master port and writes every returned word into the FIFO. The read address starts at a programmable start address and moves forward one word per beat. It wraps back to the start once the frame, which is line width times line count, has been read.

For dual scan panels a mode bit splits the FIFO into an upper half and a lower half. Each half has its own level and full signal. The controller serves the two halves in turns, using short bursts of at most 8 beats. Each half has its own address counter. The upper stream begins at the start address and the lower stream begins half a frame later. A synchronous clear aborts any burst, flushes the FIFO pointers and reloads both counters at the start of a frame.

The bus handshake works as follows. A beat is transferred in any cycle where `bus_req`, `bus_gnt` and `bus_dvalid` are all high. `bus_addr` gives the word address of that beat. The burst ends when `bus_req` falls.

Top module: `vline_fetch`

## Requirements
- R1: In single scan mode (`cfg_dual`=0) the controller arms when `lvl_a` is strictly below `cfg_wm`. Two cycles after the level drops, `bus_req` is high. A level equal to or above the watermark never starts a fetch.
- R2: A started fetch delivers one FIFO write per granted beat, in consecutive cycles, until the target half reports full. In the cycle that full is high, `bus_req` is low and no write takes place. The fetch then stays idle until the level falls below the watermark again.
- R3: In dual scan mode each half arms when its level is below `cfg_wm` shifted right by one, so the LSB of the watermark has no effect. In single scan mode `lvl_b` and `full_b` are ignored, and `fifo_wr_b` never rises.
- R4: In dual scan mode a burst carries at most 8 beats, followed by one idle cycle. When both halves want data, the halves alternate, and the upper half goes first after reset or clear.
- R5: Upper half words come from `cfg_base + n`. Lower half words come from `cfg_base + width*lines/2 + n`. Here `n` is the count of words already read by that stream, and it grows by one per beat.
- R6: A stream wraps back to its first address after its last word. In single mode the last word is the word at offset `width*lines - 1`. In dual mode it is the word at offset `width*lines/2 - 1` within the half.
- R7: A burst cut short by full keeps its address. The next burst to that half resumes at the word that was not transferred.
- R8: While `clr` is high, `bus_req` is low and `fifo_flush` is high. After `clr`, both streams restart at their first addresses.
- R9: `wm_warn` is high exactly when `cfg_wm` is greater than 16.
- R10: After reset `bus_req`, `fifo_wr_a` and `fifo_wr_b` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous frame clear |
| cfg_dual | input | 1 | 1 selects dual scan (split FIFO) |
| cfg_base | input | AW | Start word address of the frame |
| cfg_wm | input | LVLW | Refill watermark in words |
| cfg_width | input | DIMW | Words per line |
| cfg_lines | input | DIMW | Lines per frame |
| lvl_a | input | LVLW | Fill level of upper/only FIFO half |
| lvl_b | input | LVLW | Fill level of lower FIFO half |
| full_a | input | 1 | Upper/only half full |
| full_b | input | 1 | Lower half full |
| bus_gnt | input | 1 | Bus grant |
| bus_dvalid | input | 1 | Read data valid this cycle |
| bus_rdata | input | DW | Read data |
| bus_req | output | 1 | Burst request, held for the burst |
| bus_addr | output | AW | Word address of the current beat |
| fifo_wr_a | output | 1 | Write strobe, upper/only half |
| fifo_wr_b | output | 1 | Write strobe, lower half |
| fifo_wdata | output | DW | FIFO write data |
| fifo_flush | output | 1 | Clears FIFO pointers |
| wm_warn | output | 1 | Watermark above 16 (underflow risk) |

## Verification
The refill decision is tested with a set of level/watermark/full combinations, each applied right after a clear. Levels just below and exactly at the watermark separate a strict comparison from an inclusive one. A watermark of 17 in dual mode shows whether its LSB is ignored. Low lower-half levels in single mode show whether the lower half is wrongly serviced. Directed runs then cover several cases: a full frame of beats to check the wrap point, a full pulse in mid-burst to check both the early stop and the resume address, and both halves hungry to check the 8-beat cap, the alternation order and the half-frame offset.

// File: rtl/vline_fetch.sv
module vline_fetch #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LVLW = 6,
  parameter int DIMW = 10,
  parameter int DUAL_BEATS = 8,
  parameter int WARN_LVL = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cfg_dual,
  input  logic [AW-1:0]   cfg_base,
  input  logic [LVLW-1:0] cfg_wm,
  input  logic [DIMW-1:0] cfg_width,
  input  logic [DIMW-1:0] cfg_lines,
  input  logic [LVLW-1:0] lvl_a,
  input  logic [LVLW-1:0] lvl_b,
  input  logic            full_a,
  input  logic            full_b,
  input  logic            bus_gnt,
  input  logic            bus_dvalid,
  input  logic [DW-1:0]   bus_rdata,
  output logic            bus_req,
  output logic [AW-1:0]   bus_addr,
  output logic            fifo_wr_a,
  output logic            fifo_wr_b,
  output logic [DW-1:0]   fifo_wdata,
  output logic            fifo_flush,
  output logic            wm_warn
);
  localparam int FW  = 2 * DIMW;
  localparam int BCW = $clog2(DUAL_BEATS) + 1;

  logic [FW-1:0]   frame_w, span, pos_a, pos_b;
  logic [LVLW-1:0] thr;
  logic            active, tgt, last, arm_a, arm_b;
  logic [BCW-1:0]  beats;
  logic            hung_a, hung_b, cand_a, cand_b, pick, tgt_full, beat;

  assign frame_w  = FW'(cfg_width) * FW'(cfg_lines);
  assign span     = cfg_dual ? (frame_w >> 1) : frame_w;
  assign thr      = cfg_dual ? {1'b0, cfg_wm[LVLW-1:1]} : cfg_wm;
  assign hung_a   = lvl_a < thr;
  assign hung_b   = cfg_dual && (lvl_b < thr);
  assign cand_a   = arm_a && !full_a;
  assign cand_b   = arm_b && !full_b;
  assign pick     = (cand_a && cand_b) ? ~last : cand_b;
  assign tgt_full = tgt ? full_b : full_a;

  assign bus_req    = active && !tgt_full && !clr;
  assign beat       = bus_req && bus_gnt && bus_dvalid;
  assign bus_addr   = tgt ? cfg_base + AW'(span) + AW'(pos_b) : cfg_base + AW'(pos_a);
  assign fifo_wr_a  = beat && !tgt;
  assign fifo_wr_b  = beat && tgt;
  assign fifo_wdata = bus_rdata;
  assign fifo_flush = clr;
  assign wm_warn    = cfg_wm > LVLW'(WARN_LVL);

  function automatic logic [FW-1:0] step_pos(input logic [FW-1:0] p, input logic [FW-1:0] lim);
    return (p + FW'(1) >= lim) ? '0 : p + FW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tgt    <= 1'b0;
      last   <= 1'b1;
      beats  <= '0;
      arm_a  <= 1'b0;
      arm_b  <= 1'b0;
      pos_a  <= '0;
      pos_b  <= '0;
    end else if (clr) begin
      active <= 1'b0;
      tgt    <= 1'b0;
      last   <= 1'b1;
      beats  <= '0;
      arm_a  <= 1'b0;
      arm_b  <= 1'b0;
      pos_a  <= '0;
      pos_b  <= '0;
    end else begin
      arm_a <= full_a ? 1'b0 : (hung_a ? 1'b1 : arm_a);
      arm_b <= (full_b || !cfg_dual) ? 1'b0 : (hung_b ? 1'b1 : arm_b);
      if (!active) begin
        if (cand_a || cand_b) begin
          active <= 1'b1;
          tgt    <= pick;
          last   <= pick;
          beats  <= '0;
        end
      end else if (tgt_full) begin
        active <= 1'b0;
      end else if (beat) begin
        beats <= beats + BCW'(1);
        if (cfg_dual && beats == BCW'(DUAL_BEATS - 1)) active <= 1'b0;
      end
      if (fifo_wr_a) pos_a <= step_pos(pos_a, span);
      if (fifo_wr_b) pos_b <= step_pos(pos_b, span);
    end
  end
endmodule

// File: rtl/vline_fetch_chk.sv
module vline_fetch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          cfg_dual,
  input logic [AW-1:0] cfg_base,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic          fifo_wr_a,
  input logic          fifo_wr_b,
  input logic          full_a,
  input logic          full_b
);
  assert_no_write_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_a |-> !full_a) and (fifo_wr_b |-> !full_b));

  assert_single_upper_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dual |-> !fifo_wr_b);

  assert_one_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_wr_a, fifo_wr_b}));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_a && $past(fifo_wr_a) && !$past(clr) && bus_addr != cfg_base)
      |-> bus_addr == $past(bus_addr) + AW'(1));

  assert_clr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !bus_req);
endmodule

bind vline_fetch vline_fetch_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_dual(cfg_dual), .cfg_base(cfg_base),
  .bus_req(bus_req), .bus_addr(bus_addr), .fifo_wr_a(fifo_wr_a), .fifo_wr_b(fifo_wr_b),
  .full_a(full_a), .full_b(full_b)
);

// File: tb/test_vline_fetch.sv
module test_vline_fetch;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, cfg_dual = 1'b0;
  logic [31:0] cfg_base = BASE;
  logic [5:0]  cfg_wm = 6'd16, lvl_a = 6'd40, lvl_b = 6'd40;
  logic [9:0]  cfg_width = 10'd4, cfg_lines = 10'd8;
  logic full_a = 1'b0, full_b = 1'b0, bus_gnt = 1'b1, bus_dvalid = 1'b1;
  logic [31:0] bus_rdata = 32'hA5A5_0000;
  logic bus_req, fifo_wr_a, fifo_wr_b, fifo_flush, wm_warn;
  logic [31:0] bus_addr, fifo_wdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vline_fetch i_vline_fetch (.*);

  // {dual, wm, lvl_a, lvl_b, full_a, full_b, exp_req, exp_wa, exp_wb, addr_off}
  localparam logic [31:0] VEC [8] = '{
    {1'b0, 6'd16, 6'd10, 6'd40, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0},
    {1'b0, 6'd16, 6'd16, 6'd40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
    {1'b0, 6'd16, 6'd5,  6'd40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
    {1'b0, 6'd8,  6'd7,  6'd40, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0},
    {1'b1, 6'd16, 6'd10, 6'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd16},
    {1'b1, 6'd17, 6'd7,  6'd9,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0},
    {1'b1, 6'd16, 6'd2,  6'd2,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0},
    {1'b0, 6'd16, 6'd20, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic restart();
    clr = 1'b1;
    step();
    clr = 1'b0;
    step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    chk("R10 req", {31'b0, bus_req}, 0);
    chk("R10 wr", {30'b0, fifo_wr_a, fifo_wr_b}, 0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 8; i++) begin
      {cfg_dual, cfg_wm, lvl_a, lvl_b, full_a, full_b} = VEC[i][31:11];
      restart();
      chk($sformatf("R1/R3 vec%0d req", i), {31'b0, bus_req}, {31'b0, VEC[i][10]});
      chk($sformatf("R3/R4 vec%0d wr_a", i), {31'b0, fifo_wr_a}, {31'b0, VEC[i][9]});
      chk($sformatf("R3 vec%0d wr_b", i), {31'b0, fifo_wr_b}, {31'b0, VEC[i][8]});
      if (VEC[i][10]) chk($sformatf("R5 vec%0d addr", i), bus_addr, BASE + {24'b0, VEC[i][7:0]});
    end

    cfg_dual = 1'b0; cfg_wm = 6'd16; lvl_a = 6'd4; lvl_b = 6'd40; full_a = 1'b0; full_b = 1'b0;
    restart();
    chk("R8 restart addr", bus_addr, BASE);
    chk("R2 wdata", fifo_wdata, 32'hA5A5_0000);
    step(3);
    chk("R5 addr after 3 beats", bus_addr, BASE + 3);
    chk("R2 continuous writes", {31'b0, fifo_wr_a}, 1);
    step(2);
    full_a = 1'b1;
    #1;
    chk("R2 req drops on full", {31'b0, bus_req}, 0);
    chk("R2 no write when full", {31'b0, fifo_wr_a}, 0);
    step(3);
    chk("R2 idle while full", {31'b0, bus_req}, 0);
    full_a = 1'b0;
    step(2);
    chk("R7 resume req", {31'b0, bus_req}, 1);
    chk("R7 resume addr", bus_addr, BASE + 5);
    step(26);
    chk("R6 last word", bus_addr, BASE + 31);
    step();
    chk("R6 wrap to base", bus_addr, BASE);

    clr = 1'b1;
    #1;
    chk("R8 req low in clr", {31'b0, bus_req}, 0);
    chk("R8 flush", {31'b0, fifo_flush}, 1);
    step();
    clr = 1'b0;
    step(2);
    chk("R8 reload addr", bus_addr, BASE);

    cfg_dual = 1'b1; lvl_a = 6'd2; lvl_b = 6'd2;
    restart();
    chk("R4 upper first", {31'b0, fifo_wr_a}, 1);
    step(7);
    chk("R4 eighth beat upper", {31'b0, fifo_wr_a}, 1);
    chk("R5 upper addr", bus_addr, BASE + 7);
    step();
    chk("R4 gap after 8 beats", {31'b0, bus_req}, 0);
    step();
    chk("R4 lower next", {31'b0, fifo_wr_b}, 1);
    chk("R5 lower start", bus_addr, BASE + 16);
    step(8);
    chk("R4 gap after lower", {31'b0, bus_req}, 0);
    step();
    chk("R4 back to upper", {31'b0, fifo_wr_a}, 1);
    chk("R5 upper continues", bus_addr, BASE + 8);

    cfg_wm = 6'd20;
    #1;
    chk("R9 warn high", {31'b0, wm_warn}, 1);
    cfg_wm = 6'd16;
    #1;
    chk("R9 warn low", {31'b0, wm_warn}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule